// File: doc/BRIEF.md
# Dead-Band Generator with Polarity Select

This block turns two raw PWM drive signals into a shaped pair suitable for the high-side and low-side switches of a half bridge. One path delays only the low-to-high transitions of its input (the rising-edge delay path). The other path delays only the high-to-low transitions of its input (the falling-edge delay path). Both delays are counted in clock cycles. Each path chooses its source (raw A or raw B). Each path output can be inverted. Each block output either carries its shaped path or passes the raw input straight through.

The usual setup feeds both paths from A and inverts the falling-edge path. The result is a complementary pair in which neither switch turns on until the other has been off for the programmed dead time. A delay of zero adds no latency at all. A delay value is captured at the edge it applies to, so rewriting it while the input rests at a level never disturbs the output. This also holds when the delay goes from zero to non-zero at 0 % or 100 % duty.

Top module: `dead_band_gen`

## Requirements
- R1: With a non-zero rising delay D, the rising path output goes high exactly D cycles after its input goes high (when the input stays high that long). It goes low in the same cycle as the input.
- R2: With a non-zero falling delay D, the falling path output goes low exactly D cycles after its input goes low (when the input stays low that long). It goes high in the same cycle as the input.
- R3: A delay of 0 makes the path output equal to its input in the same cycle, with no register in the path.
- R4: An input pulse that lasts D cycles or fewer, against a path delay D, produces no pulse at that path's output.
- R5: The delay value in force is the one present in the cycle of the qualifying edge. A new value written while a count runs changes nothing until the next qualifying edge.
- R6: While a path input holds its level, changing that path's delay never changes the output level. This includes changing the delay from 0 to a non-zero value.
- R7: cfg_src[0] picks the rising path source and cfg_src[1] picks the falling path source. For each bit, 0 selects pwm_a_in and 1 selects pwm_b_in.
- R8: cfg_pol[0]=1 inverts the rising path output and cfg_pol[1]=1 inverts the falling path output. A value of 0 leaves the output true.
- R9: cfg_oen[0]=1 drives out_a from the rising path, and cfg_oen[0]=0 drives out_a from pwm_a_in directly. cfg_oen[1] does the same for out_b, with the falling path and pwm_b_in.
- R10: Reset leaves both paths idle, as if their inputs had just been at the inactive level. With both inputs low, out_a is low. With the falling path inverted, out_b is also low and rises only after the falling delay has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all delays count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| pwm_a_in | input | 1 | Raw PWM signal A |
| pwm_b_in | input | 1 | Raw PWM signal B |
| red_cnt | input | DLY_W | Rising-edge delay in cycles |
| fed_cnt | input | DLY_W | Falling-edge delay in cycles |
| cfg_src | input | 2 | Path source select (bit 0 rising, bit 1 falling; 1 = B) |
| cfg_pol | input | 2 | Path output inversion (bit 0 rising, bit 1 falling) |
| cfg_oen | input | 2 | Output uses shaped path when 1, raw input when 0 |
| out_a | output | 1 | Shaped output A |
| out_b | output | 1 | Shaped output B |

## Verification
Long square waves show the exact turn-on lag and the immediate turn-off on each path. Pulse trains swept from one cycle up to one beyond the delay locate the swallow boundary to the cycle. Delay rewrites during a running count, and at a static high or low level, separate capture-at-edge from live use of the count (the zero-to-non-zero case at full duty included). Random held-level patterns under every source, polarity and output-enable setting show that the routing muxes pick the right signal.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int DLY_W       = 10;
    localparam int DLY_DEFAULT = 50;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    typedef struct packed {
        logic from_b;
        logic invert;
        logic shaped;
    } path_cfg_t;

    function automatic logic pick_src(input logic from_b, input logic a, input logic b);
        return from_b ? b : a;
    endfunction

endpackage

// File: rtl/dbg_src_sel.sv
module dbg_src_sel (
    input  logic              a_in,
    input  logic              b_in,
    input  dbg_pkg::path_cfg_t cfg,
    output logic              y
);
    assign y = dbg_pkg::pick_src(cfg.from_b, a_in, b_in);
endmodule

// File: rtl/dbg_edge_delay.sv
module dbg_edge_delay #(
    parameter int                  DLY_W = dbg_pkg::DLY_W,
    parameter dbg_pkg::edge_kind_e KIND  = dbg_pkg::EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic [DLY_W-1:0] dly,
    output logic             sig_out
);
    // Core delays the rise of x; the falling variant wraps it in inverters.
    logic             x;
    logic             y_core;
    logic             lvl;
    logic             busy;
    logic             fire;
    logic [DLY_W-1:0] cnt;

    generate
        if (KIND == dbg_pkg::EDGE_RISE) begin : g_rise
            assign x       = sig_in;
            assign sig_out = y_core;
        end else begin : g_fall
            assign x       = ~sig_in;
            assign sig_out = ~y_core;
        end
    endgenerate

    assign fire   = x & ~lvl & (busy ? (cnt == '0) : (dly == '0));
    assign y_core = x & (lvl | fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl  <= 1'b0;
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!x) begin
            lvl  <= 1'b0;
            busy <= 1'b0;
        end else if (lvl) begin
            lvl  <= 1'b1;
        end else if (fire) begin
            lvl  <= 1'b1;
            busy <= 1'b0;
        end else if (!busy) begin
            busy <= 1'b1;
            cnt  <= dly - DLY_W'(1);
        end else begin
            cnt  <= cnt - DLY_W'(1);
        end
    end

    // R1: a qualifying edge with non-zero delay never shows at once
    a_r1_edge_waits: assert property (@(posedge clk) disable iff (rst)
        (x && !$past(x) && dly != '0) |-> !y_core);

    // R3: zero delay passes the edge in the same cycle
    a_r3_zero_passes: assert property (@(posedge clk) disable iff (rst)
        (x && !$past(x) && dly == '0) |-> y_core);

    // R6: once the output is active it stays so while the input holds
    a_r6_level_held: assert property (@(posedge clk) disable iff (rst)
        (x && $past(x) && $past(y_core)) |-> y_core);

    // R5: a running count follows its captured value, not the live delay
    a_r5_count_latched: assert property (@(posedge clk) disable iff (rst)
        (busy && x && cnt != '0) |=> (busy && cnt == $past(cnt) - DLY_W'(1)));

endmodule

// File: rtl/dbg_out_stage.sv
module dbg_out_stage (
    input  logic               raw_in,
    input  logic               shaped_in,
    input  dbg_pkg::path_cfg_t cfg,
    output logic               y
);
    assign y = cfg.shaped ? (shaped_in ^ cfg.invert) : raw_in;
endmodule

// File: rtl/dead_band_gen.sv
module dead_band_gen #(
    parameter int DLY_W = dbg_pkg::DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_a_in,
    input  logic             pwm_b_in,
    input  logic [DLY_W-1:0] red_cnt,
    input  logic [DLY_W-1:0] fed_cnt,
    input  logic [1:0]       cfg_src,
    input  logic [1:0]       cfg_pol,
    input  logic [1:0]       cfg_oen,
    output logic             out_a,
    output logic             out_b
);
    import dbg_pkg::*;

    localparam int NPATH = 2;

    path_cfg_t        cfg      [NPATH];
    logic [DLY_W-1:0] dly      [NPATH];
    logic [NPATH-1:0] raw;
    logic [NPATH-1:0] path_in;
    logic [NPATH-1:0] path_out;
    logic [NPATH-1:0] pin_out;

    assign raw    = {pwm_b_in, pwm_a_in};
    assign dly[0] = red_cnt;
    assign dly[1] = fed_cnt;

    generate
        for (genvar i = 0; i < NPATH; i++) begin : g_path
            assign cfg[i] = '{from_b: cfg_src[i], invert: cfg_pol[i], shaped: cfg_oen[i]};

            dbg_src_sel u_src (
                .a_in (pwm_a_in),
                .b_in (pwm_b_in),
                .cfg  (cfg[i]),
                .y    (path_in[i])
            );

            dbg_edge_delay #(
                .DLY_W (DLY_W),
                .KIND  (edge_kind_e'(i))
            ) u_dly (
                .clk     (clk),
                .rst     (rst),
                .sig_in  (path_in[i]),
                .dly     (dly[i]),
                .sig_out (path_out[i])
            );

            dbg_out_stage u_out (
                .raw_in    (raw[i]),
                .shaped_in (path_out[i]),
                .cfg       (cfg[i]),
                .y         (pin_out[i])
            );
        end
    endgenerate

    assign out_a = pin_out[0];
    assign out_b = pin_out[1];

endmodule

// File: tb/tb_dead_band_gen.sv
module tb_dead_band_gen;
    localparam int W = dbg_pkg::DLY_W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         a_in = 1'b0, b_in = 1'b0;
    logic [W-1:0] red_v = W'(5), fed_v = W'(3);
    logic [1:0]   src_v = 2'b00, pol_v = 2'b10, oen_v = 2'b11;
    logic [W-1:0] nx_red = W'(5), nx_fed = W'(3);
    logic [1:0]   nx_src = 2'b00, nx_pol = 2'b10, nx_oen = 2'b11;
    logic         out_a, out_b;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    int run_r = 0, d_r = 0, run_f = 0, d_f = 0;
    logic [15:0] lf = 16'hACE1;

    always #10 clk = ~clk;

    dead_band_gen #(.DLY_W(W)) dut (
        .clk(clk), .rst(rst), .pwm_a_in(a_in), .pwm_b_in(b_in),
        .red_cnt(red_v), .fed_cnt(fed_v), .cfg_src(src_v),
        .cfg_pol(pol_v), .cfg_oen(oen_v), .out_a(out_a), .out_b(out_b)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", tag, nm, cyc, act, exp);
        end
    endtask

    // One clock: apply inputs after the edge, compare model before the next.
    task automatic step(input logic a, input logic b, input string ta, input string tb);
        logic xr, xf, yr, yf, ea, eb;
        @(posedge clk);
        #2;
        rst = 0; a_in = a; b_in = b;
        red_v = nx_red; fed_v = nx_fed; src_v = nx_src; pol_v = nx_pol; oen_v = nx_oen;
        @(negedge clk);
        xr = src_v[0] ? b_in : a_in;
        xf = !(src_v[1] ? b_in : a_in);
        if (xr) begin
            if (run_r == 0) d_r = int'(red_v);
            run_r++;
        end else run_r = 0;
        if (xf) begin
            if (run_f == 0) d_f = int'(fed_v);
            run_f++;
        end else run_f = 0;
        yr = xr && (run_r >= d_r + 1);
        yf = !(xf && (run_f >= d_f + 1));
        ea = oen_v[0] ? (yr ^ pol_v[0]) : a_in;
        eb = oen_v[1] ? (yf ^ pol_v[1]) : b_in;
        chk(ta, "out_a", out_a, ea);
        chk(tb, "out_b", out_b, eb);
    endtask

    task automatic hold(input logic a, input logic b, input int n, input string ta, input string tb);
        for (int i = 0; i < n; i++) step(a, b, ta, tb);
    endtask

    task automatic rand_run(input int n, input string ta, input string tb);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            hold(lf[4], lf[9], int'(lf[2:0]) + 1, ta, tb);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state, inputs low, falling path inverted
        chk("R10", "out_a", out_a, 1'b0);
        chk("R10", "out_b", out_b, 1'b0);
        hold(0, 0, 10, "R10", "R10");

        // R1 / R2: square waves on A, complementary pair
        for (int k = 0; k < 3; k++) begin
            hold(1, 0, 20, "R1", "R2");
            hold(0, 0, 20, "R1", "R2");
        end

        // R4: pulses around the swallow boundary
        nx_red = W'(5); nx_fed = W'(5);
        for (int w = 1; w <= 7; w++) begin
            hold(1, 0, w, "R4", "R4");
            hold(0, 0, 8, "R4", "R4");
        end
        hold(1, 0, 10, "R4", "R4");
        for (int w = 1; w <= 7; w++) begin
            hold(0, 0, w, "R4", "R4");
            hold(1, 0, 8, "R4", "R4");
        end

        // R3: zero delays, fast random pattern
        nx_red = '0; nx_fed = '0;
        for (int i = 0; i < 200; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[5], "R3", "R3");
        end

        // R5: delay rewritten while a count runs
        nx_red = W'(8); nx_fed = W'(8);
        hold(0, 0, 12, "R5", "R5");
        hold(1, 0, 3, "R5", "R5");
        nx_red = W'(2);
        hold(1, 0, 12, "R5", "R5");
        hold(0, 0, 3, "R5", "R5");
        nx_fed = W'(2);
        hold(0, 0, 12, "R5", "R5");
        hold(1, 0, 4, "R5", "R5");

        // R6: delay changed at a static level, including zero to non-zero
        nx_red = '0; nx_fed = '0;
        hold(1, 0, 5, "R6", "R6");
        nx_red = W'(50);
        hold(1, 0, 60, "R6", "R6");
        nx_red = '0;
        hold(1, 0, 3, "R6", "R6");
        nx_red = W'(50);
        hold(1, 0, 10, "R6", "R6");
        hold(0, 0, 5, "R6", "R6");
        nx_fed = W'(50);
        hold(0, 0, 60, "R6", "R6");

        // R7: source selects
        nx_red = W'(3); nx_fed = W'(4);
        nx_src = 2'b01; rand_run(60, "R7", "R7");
        nx_src = 2'b10; rand_run(60, "R7", "R7");
        nx_src = 2'b11; rand_run(60, "R7", "R7");
        nx_src = 2'b00;

        // R8: polarity selects
        nx_pol = 2'b00; rand_run(60, "R8", "R8");
        nx_pol = 2'b11; rand_run(60, "R8", "R8");
        nx_pol = 2'b01; rand_run(60, "R8", "R8");
        nx_pol = 2'b10;

        // R9: output enables and raw bypass
        nx_oen = 2'b00; rand_run(60, "R9", "R9");
        nx_oen = 2'b01; rand_run(60, "R9", "R9");
        nx_oen = 2'b10; rand_run(60, "R9", "R9");
        nx_oen = 2'b11;

        // R1 / R2 with the customary 50-cycle dead time
        nx_red = W'(dbg_pkg::DLY_DEFAULT); nx_fed = W'(dbg_pkg::DLY_DEFAULT);
        hold(0, 0, 60, "R1", "R2");
        hold(1, 0, 120, "R1", "R2");
        hold(0, 0, 120, "R1", "R2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule